// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges seven reset requests into a single stretched system reset and records the cause of the most recent reset in one 8-bit register. The requests are: power-on or supply monitor, an external active-low reset pin, a missing-clock timeout, a watchdog timeout, a software force, an active-low comparator level and a flash-access error. The comparator, the supply monitor, the watchdog counter and the clock detector sit outside the block. Each appears here as one request line.

Software reaches the register through a small bus port with address, write enable, write data and combinational read data. Several bits have split meanings. A write sets an enable or forces an action, while a read returns the latched cause flag. Enables are held in storage separate from the flags. The flags are replaced only on the cycle a new reset begins.

The async reset `rst_ni` is the true power-on event. It sets the power-on flag and the default enables, and it starts a full-length system reset.

Top module: `rst_src_ctrl`

## Requirements
- R1: The register answers at address 0xEF. Bit 7 always reads 0, and writing it has no effect. A read of any other address returns 0.
- R2: After `rst_ni` is released, `sys_rst_o` is high for 16 cycles and the register reads 0x02 (bit 1 only). The comparator and missing-clock enables are cleared, and the supply-monitor enable is set.
- R3: `sys_rst_o` stays high for 16 cycles after the last cycle on which any request was present, so a one-cycle request gives exactly 16 high cycles.
- R4: A watchdog request sets flag bit 3, and a flash-error request sets flag bit 6. A low `pin_rst_ni` sets flag bit 0 after a 2-flop synchronizer.
- R5: Writing 0xEF with data bit 4 = 1 forces a reset and sets flag bit 4. Writing bit 4 = 0 causes no reset.
- R6: Write bit 5 is the comparator enable. When it is set, a low `cmp_i` (2-flop synchronized) causes a reset and sets flag bit 5. When it is clear, `cmp_i` is ignored.
- R7: Write bit 2 is the missing-clock enable. When it is set, `clk_miss_i` causes a reset and sets flag bit 2. When it is clear, `clk_miss_i` is ignored.
- R8: Write bit 1 is the supply-monitor enable. When it is set, `supply_low_i` causes a reset that sets flag bit 1 and clears every other flag. When it is clear, `supply_low_i` is ignored.
- R9: Flags are captured only on the first cycle of a reset. Every source requesting on that cycle sets its flag, and all other flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Async active-low power-on reset |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| cmp_i | input | 1 | Comparator level, trips when low, asynchronous |
| supply_low_i | input | 1 | Supply monitor request |
| clk_miss_i | input | 1 | Missing-clock request, synchronous |
| wdt_timeout_i | input | 1 | Watchdog timeout request |
| flash_err_i | input | 1 | Flash access error request |
| reg_addr_i | input | 8 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sys_rst_o | output | 1 | Stretched system reset, active high |

## Verification
Assertions check four things on every cycle:
- any request raises the system reset on the next cycle;
- a set power-on flag excludes all other flags;
- flags move only on the first cycle of a reset;
- a comparator-caused reset start implies the comparator enable is set.

The exact 16-cycle stretch, the synchronizer delay, the enable defaults after power-on, and the cases where a disabled source or a zero bit 4 leaves the reset quiet can only be shown by the bench's directed scenarios.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  localparam int NUM_SRC   = 7;
  localparam int BIT_PIN   = 0;
  localparam int BIT_POR   = 1;
  localparam int BIT_MCLK  = 2;
  localparam int BIT_WDOG  = 3;
  localparam int BIT_SOFT  = 4;
  localparam int BIT_CMP   = 5;
  localparam int BIT_FLASH = 6;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // inputs idle high, so the flops reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  // power-on starts a full-length reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CW'(HOLD);
    else if (req_i)         cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_req_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> active_o);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_src_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  src_vec_t req_i,
  input  logic     wr_i,
  input  logic     cmp_en_d_i,
  input  logic     mclk_en_d_i,
  input  logic     vmon_en_d_i,
  output src_vec_t flags_o,
  output logic     cmp_en_o,
  output logic     mclk_en_o,
  output logic     vmon_en_o
);
  localparam src_vec_t POR_ONLY = src_vec_t'(1) << BIT_POR;

  src_vec_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= POR_ONLY;
    else if (start_i) flags_q <= req_i[BIT_POR] ? POR_ONLY : req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_en_o  <= 1'b0;
      mclk_en_o <= 1'b0;
      vmon_en_o <= 1'b1;
    end else if (wr_i) begin
      cmp_en_o  <= cmp_en_d_i;
      mclk_en_o <= mclk_en_d_i;
      vmon_en_o <= vmon_en_d_i;
    end
  end

  assign flags_o = flags_q;

  assert_por_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[BIT_POR] |-> ((flags_q & ~POR_ONLY) == '0));

  assert_capture_on_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags_q) |-> $past(start_i));
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'hEF,
  parameter int         HOLD     = 16,
  parameter int         SYNC_STG = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_rst_ni,
  input  logic       cmp_i,
  input  logic       supply_low_i,
  input  logic       clk_miss_i,
  input  logic       wdt_timeout_i,
  input  logic       flash_err_i,
  input  logic [7:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sys_rst_o
);
  logic [1:0] async_in, sync_out;
  src_vec_t   req, flags;
  logic       hit, wr, any_req, start;
  logic       cmp_en, mclk_en, vmon_en;
  logic       unused_wdata;

  assign async_in = {cmp_i, pin_rst_ni};

  rst_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_in),
    .sync_o (sync_out)
  );

  assign hit = (reg_addr_i == REG_ADDR);
  assign wr  = hit & reg_we_i;

  always_comb begin
    req             = '0;
    req[BIT_PIN]    = ~sync_out[0];
    req[BIT_POR]    = supply_low_i & vmon_en;
    req[BIT_MCLK]   = clk_miss_i & mclk_en;
    req[BIT_WDOG]   = wdt_timeout_i;
    req[BIT_SOFT]   = wr & reg_wdata_i[BIT_SOFT];
    req[BIT_CMP]    = ~sync_out[1] & cmp_en;
    req[BIT_FLASH]  = flash_err_i;
  end

  assign any_req = |req;
  assign start   = any_req & ~sys_rst_o;

  rst_stretch #(.HOLD(HOLD)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (any_req),
    .active_o(sys_rst_o)
  );

  rst_cause_reg u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_i      (req),
    .wr_i       (wr),
    .cmp_en_d_i (reg_wdata_i[BIT_CMP]),
    .mclk_en_d_i(reg_wdata_i[BIT_MCLK]),
    .vmon_en_d_i(reg_wdata_i[BIT_POR]),
    .flags_o    (flags),
    .cmp_en_o   (cmp_en),
    .mclk_en_o  (mclk_en),
    .vmon_en_o  (vmon_en)
  );

  // bit 7 is unused: reads 0
  assign reg_rdata_o = hit ? {1'b0, flags} : 8'h00;

  assign unused_wdata = ^{reg_wdata_i[7], reg_wdata_i[BIT_FLASH],
                          reg_wdata_i[BIT_WDOG], reg_wdata_i[BIT_PIN]};

  assert_cmp_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && req[BIT_CMP]) |-> cmp_en);
endmodule

// File: tb/tb_rst_src_ctrl.sv
module tb_rst_src_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pin_n = 1, cmp = 1, sup = 0, mclk = 0, wdt = 0, ferr = 0;
  logic [7:0] addr = 8'hEF, wdata = 0, rdata;
  logic       we = 0, srst;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rst_src_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_rst_ni(pin_n), .cmp_i(cmp),
    .supply_low_i(sup), .clk_miss_i(mclk), .wdt_timeout_i(wdt),
    .flash_err_i(ferr), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sys_rst_o(srst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_count(output int n);
    n = 0;
    while (srst && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rise();
    for (int k = 0; k < 8 && !srst; k++) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    int hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); hi += srst; end
    chk(req, hi, 0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; we = 0; #1; v = rdata; addr = 8'hEF;
  endtask

  task automatic wr(input logic [7:0] d);
    addr = 8'hEF; wdata = d; we = 1;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic expect_flags(input string req, input logic [7:0] e);
    logic [7:0] v;
    rd(8'hEF, v); chk(req, v, e);
  endtask

  task automatic t_por();
    int n;
    @(negedge clk); rst_n = 1;
    hold_count(n); chk("R2 por hold", n, 16);
    expect_flags("R2 por flag", 8'h02);
  endtask

  task automatic t_wdt_pulse();
    int n;
    wdt = 1; @(negedge clk); wdt = 0;
    hold_count(n); chk("R3 one-cycle hold", n, 16);
    expect_flags("R4 wdt flag", 8'h08);
  endtask

  task automatic t_extend();
    int n;
    wdt = 1; @(negedge clk);
    repeat (4) @(negedge clk);
    wdt = 0;
    hold_count(n); chk("R3 hold after release", n, 16);
  endtask

  task automatic t_pin();
    int n;
    pin_n = 0; @(negedge clk); pin_n = 1;
    wait_rise(); chk("R4 pin causes reset", srst, 1);
    hold_count(n);
    expect_flags("R4 pin flag", 8'h01);
  endtask

  task automatic t_soft();
    int n;
    wr(8'h02); quiet("R5 bit4 zero no reset");
    expect_flags("R5 flags kept", 8'h01);
    wr(8'h12);
    hold_count(n); chk("R5 soft hold", n, 16);
    expect_flags("R5 soft flag", 8'h10);
  endtask

  task automatic t_cmp();
    int n;
    cmp = 0; quiet("R6 cmp disabled ignored"); cmp = 1;
    repeat (3) @(negedge clk);
    wr(8'h22);
    cmp = 0; @(negedge clk); cmp = 1;
    wait_rise(); chk("R6 cmp causes reset", srst, 1);
    hold_count(n);
    expect_flags("R6 cmp flag", 8'h20);
  endtask

  task automatic t_mclk();
    int n;
    wr(8'h02);
    mclk = 1; quiet("R7 mclk disabled ignored"); mclk = 0;
    wr(8'h06);
    mclk = 1; @(negedge clk); mclk = 0;
    hold_count(n);
    expect_flags("R7 mclk flag", 8'h04);
  endtask

  task automatic t_flash_multi();
    int n;
    ferr = 1; @(negedge clk); ferr = 0;
    hold_count(n); expect_flags("R4 flash flag", 8'h40);
    ferr = 1; wdt = 1; @(negedge clk); ferr = 0; wdt = 0;
    hold_count(n); expect_flags("R9 simultaneous flags", 8'h48);
    // late request during active reset must not re-capture
    wdt = 1; @(negedge clk); wdt = 0;
    @(negedge clk); ferr = 1; @(negedge clk); ferr = 0;
    hold_count(n); expect_flags("R9 no capture mid-reset", 8'h08);
  endtask

  task automatic t_supply();
    int n;
    sup = 1; wdt = 1; @(negedge clk); sup = 0; wdt = 0;
    hold_count(n); chk("R8 supply hold", n, 16);
    expect_flags("R8 supply clears others", 8'h02);
    wr(8'h00);
    sup = 1; quiet("R8 supply disabled ignored"); sup = 0;
  endtask

  task automatic t_bit7();
    logic [7:0] v;
    wr(8'h82); quiet("R1 bit7 write no reset");
    expect_flags("R1 bit7 reads 0", 8'h02);
    rd(8'hEE, v); chk("R1 other address reads 0", v, 0);
  endtask

  task automatic t_por_again();
    int n;
    wr(8'h26);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    hold_count(n); chk("R2 por restart hold", n, 16);
    expect_flags("R2 por flag again", 8'h02);
    cmp = 0; quiet("R2 cmp enable cleared"); cmp = 1;
    mclk = 1; quiet("R2 mclk enable cleared"); mclk = 0;
    sup = 1; @(negedge clk); sup = 0;
    hold_count(n); chk("R2 vmon enable set", n, 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_por();
    t_wdt_pulse();
    t_extend();
    t_pin();
    t_soft();
    t_cmp();
    t_mclk();
    t_flash_multi();
    t_supply();
    t_bit7();
    t_por_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule